// File: doc/BRIEF.md
# Selectable Add / Multiply / Compare Unit

This block is a purely combinational arithmetic unit. It takes two unsigned operands and a two-bit function select, and drives one result bus that is twice as wide as an operand. The select picks one of three functions: a sum, a full product, or a magnitude comparison. A fourth select code forces the result to zero.

Every function is built from gate-level terms, and no native addition or multiplication operator is used. The product comes from an array of AND-gate partial products. A first row passes its terms straight through. A chain of full-adder rows follows, and each of those rows retires one low product bit. A final ripple row of full adders forms the upper half of the product. The sum comes from cascaded four-bit carry-lookahead groups. Inside each group, every carry is expanded as a sum of products of the generate and propagate terms and the group carry-in. The comparator scans from the most significant bit down. The unit holds no state, so its result follows the operands and the select within the same evaluation.

Top module: `arith_select_unit`

## Requirements
- R1: With `func_sel` = 2'b00, `result[8:0]` equals the unsigned sum `op_a + op_b`, with a carry-in of zero, and `result[15:9]` is zero.
- R2: In add mode, the carry out of the top adder bit appears in `result[8]`. For example, 0xFF + 0xFF gives 0x01FE.
- R3: With `func_sel` = 2'b01, `result` equals the full 16-bit unsigned product `op_a * op_b`. For example, 0xFF * 0xFF gives 0xFE01.
- R4: In multiply mode, a zero operand on either side gives an all-zero result.
- R5: With `func_sel` = 2'b10, `result[0]` is 1 when op_a > op_b, `result[1]` is 1 when op_a == op_b, `result[2]` is 1 when op_a < op_b, and `result[15:3]` is zero.
- R6: In compare mode, exactly one of `result[2:0]` is set for every operand pair.
- R7: With `func_sel` = 2'b11, `result` is all zeros whatever the operands are.
- R8: The unit has no state. After a change of operands or select, the result settles without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First unsigned operand |
| op_b | input | 8 | Second unsigned operand |
| func_sel | input | 2 | Function select: 00 add, 01 multiply, 10 compare, 11 zero |
| result | output | 16 | Selected function result |

## Verification
The hardest cases to reach are the long carry chains. These are an add carry that ripples out of the lower lookahead group into bit 8, and a product in which every middle full-adder row carries at once. Random pairs seldom make all of them happen together. The stimulus therefore walks every mode through the corner operands 0x00, 0xFF, 0x01, 0x80 and 0x0F in every combination, which includes all equal pairs. Thousands of random pairs per mode follow. Each result is compared against a plain integer model. The no-state property is exercised by changing the inputs between clock edges and sampling after a short delay.

// File: rtl/arith_select_unit.sv
module arith_select_unit #(
  parameter int W   = 8,
  parameter int GRP = 4
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [1:0]     func_sel,
  output logic [2*W-1:0] result
);
  localparam int RW = 2 * W;
  localparam int PW = W - 1;
  localparam int NG = W / GRP;

  // Partial-product array
  logic [PW-1:0] row_s [W];
  logic [PW-1:0] row_c [W];
  logic [RW-1:0] prod;

  assign row_s[0] = op_b[W-1:1] & {PW{op_a[0]}};
  assign row_c[0] = '0;
  assign prod[0]  = op_a[0] & op_b[0];

  genvar i, k;
  for (i = 1; i < W; i++) begin : g_mrow
    logic [W-1:0]  pp;
    logic [PW-1:0] fs;
    logic [PW-1:0] fc;
    assign pp = op_b & {W{op_a[i]}};
    for (k = 0; k < PW; k++) begin : g_fa
      assign fs[k] = row_s[i-1][k] ^ row_c[i-1][k] ^ pp[k];
      assign fc[k] = (row_s[i-1][k] & row_c[i-1][k]) |
                     (row_s[i-1][k] & pp[k]) |
                     (row_c[i-1][k] & pp[k]);
    end
    assign prod[i]  = fs[0];
    assign row_s[i] = {pp[W-1], fs[PW-1:1]};
    assign row_c[i] = fc;
  end

  logic [W-1:0] fr_c;
  assign fr_c[0] = 1'b0;
  for (k = 0; k < PW; k++) begin : g_final
    assign prod[W+k]  = row_s[W-1][k] ^ row_c[W-1][k] ^ fr_c[k];
    assign fr_c[k+1]  = (row_s[W-1][k] & row_c[W-1][k]) |
                        (row_s[W-1][k] & fr_c[k]) |
                        (row_c[W-1][k] & fr_c[k]);
  end
  assign prod[RW-1] = fr_c[W-1];

  // Cascaded lookahead groups
  logic [W:0] sum_w;
  always_comb begin
    logic cg, t;
    logic [GRP-1:0] p, g;
    logic [GRP:0] c;
    cg = 1'b0;
    sum_w = '0;
    for (int q = 0; q < NG; q++) begin
      p = op_a[q*GRP +: GRP] ^ op_b[q*GRP +: GRP];
      g = op_a[q*GRP +: GRP] & op_b[q*GRP +: GRP];
      c[0] = cg;
      for (int j = 1; j <= GRP; j++) begin
        t = cg;
        for (int n = 0; n < j; n++) t = t & p[n];
        c[j] = t;
        for (int m = 0; m < j; m++) begin
          t = g[m];
          for (int n = m + 1; n < j; n++) t = t & p[n];
          c[j] = c[j] | t;
        end
      end
      for (int j = 0; j < GRP; j++) sum_w[q*GRP + j] = p[j] ^ c[j];
      cg = c[GRP];
    end
    sum_w[W] = cg;
  end

  // Magnitude scan, most significant bit first
  logic gt, eq, lt;
  always_comb begin
    gt = 1'b0;
    lt = 1'b0;
    for (int n = W - 1; n >= 0; n--) begin
      if (!gt && !lt) begin
        gt = op_a[n] & ~op_b[n];
        lt = ~op_a[n] & op_b[n];
      end
    end
    eq = ~(gt | lt);
  end

  always_comb begin
    case (func_sel)
      2'b00:   result = {{(RW-W-1){1'b0}}, sum_w};
      2'b01:   result = prod;
      2'b10:   result = {{(RW-3){1'b0}}, lt, eq, gt};
      default: result = '0;
    endcase
  end

  always_comb begin
    assert_cmp_onehot_R6: assert ($onehot({lt, eq, gt}))
      else $error("compare flags not one-hot");
    if (func_sel == 2'b11)
      assert_idle_zero_R7: assert (result == '0) else $error("idle code not zero");
    if (func_sel == 2'b00)
      assert_add_pad_R1: assert (result[RW-1:W+1] == '0) else $error("add upper bits set");
    if (func_sel == 2'b01 && (op_a == '0 || op_b == '0))
      assert_mul_zero_R4: assert (result == '0) else $error("zero operand product");
    if (func_sel == 2'b10)
      assert_cmp_eq_R5: assert (result[1] == (op_a == op_b)) else $error("equal flag wrong");
  end
endmodule

// File: tb/sim_arith_select_unit.sv
module sim_arith_select_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  op_a = '0, op_b = '0;
  logic [1:0]  func_sel = 2'b11;
  logic [15:0] result;
  int checks = 0, errors = 0, cycles = 0;

  arith_select_unit u0 (.op_a(op_a), .op_b(op_b), .func_sel(func_sel), .result(result));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] model(input int a, input int b, input int s);
    case (s)
      0: return 16'(a + b);
      1: return 16'(a * b);
      2: return {13'b0, a < b, a == b, a > b};
      default: return 16'h0;
    endcase
  endfunction

  task automatic check_now();
    logic [15:0] exp;
    string tag;
    exp = model(int'(op_a), int'(op_b), int'(func_sel));
    case (func_sel)
      2'b00: tag = (int'(op_a) + int'(op_b) > 255) ? "R2" : "R1";
      2'b01: tag = (op_a == 0 || op_b == 0) ? "R4" : "R3";
      2'b10: tag = "R5";
      default: tag = "R7";
    endcase
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h sel=%0d actual=%h expected=%h", tag, op_a, op_b, func_sel, result, exp);
    end
    if (func_sel == 2'b10) begin
      checks++;
      if ($countones(result[2:0]) != 1) begin
        errors++;
        $display("FAIL R6 flags actual=%b expected=one-hot", result[2:0]);
      end
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [1:0] s);
    @(negedge clk);
    op_a = a; op_b = b; func_sel = s;
    @(posedge clk);
    #1 check_now();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] corner [5];
    corner[0] = 8'h00; corner[1] = 8'hFF; corner[2] = 8'h01;
    corner[3] = 8'h80; corner[4] = 8'h0F;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    #1 check_now();  // R7: idle select right after start-up
    for (int s = 0; s < 4; s++)
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          apply(corner[x], corner[y], 2'(s));
    for (int n = 0; n < 3000; n++)
      for (int s = 0; s < 4; s++)
        apply(8'($urandom), 8'($urandom), 2'(s));
    // R8: change inputs between edges, no clock edge before sampling
    @(negedge clk);
    for (int n = 0; n < 40; n++) begin
      op_a = 8'($urandom); op_b = 8'($urandom); func_sel = 2'(n % 4);
      #1 check_now();
      if (func_sel == 2'b00 && result !== model(int'(op_a), int'(op_b), 0)) begin
        errors++;
        $display("FAIL R8 actual=%h expected=%h", result, model(int'(op_a), int'(op_b), 0));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule